// File: doc/BRIEF.md
# Clock Pair Enable and Power-Down Gate

This block sits between a reference clock and a set of differential clock output drivers. For every output pair it decides, on each cycle, whether the true and complement legs follow the incoming clock, sit parked both low, or sit parked true-high/complement-low. It takes four kinds of control: a power-down pin, per-pair enable pins (only on the pairs named by a parameter mask), a polarity pin that flips the sense of both the power-down and the enable pins, and register bits (one enable per pair plus a park-mode bit) that arrive already in the clock domain.

Pin controls pass through a two-flop synchronizer clocked by the reference clock. The per-pair state then changes only on the falling edge of that clock, while it is low. A clock pulse that starts on an output therefore always runs to completion, and a suppressed pulse never appears at all. Register inputs skip the synchronizer and act on the next falling edge.

Top module: `clkgate_ctrl`

## Requirements
- R1: While `rst` is high, every pair reads true=0, complement=0 in both clock phases. A reset applied during operation parks every pair low/low from the next falling edge.
- R2: With `inv_pin`=0, power-down is asserted by `pd_pin`=0 and a pair's pin enable is asserted by `oe_pin[i]`=1. With `inv_pin`=1 both senses are flipped.
- R3: When `pair_en[i]`=0 the pair is low/low, whatever the pins and the park mode. For pairs without an enable pin (bits 1 and 2 of the default mask 4'b1001), `oe_pin[i]` has no effect on the output.
- R4: With power-down asserted, the pair enabled and (for pin-enabled pairs) the pin enable asserted, the pair parks high/low when `pd_mode`=0 and low/low when `pd_mode`=1.
- R5: With power-down deasserted, the pair enabled and the pin enable asserted where present, `out_p[i]` equals the clock and `out_n[i]` is its inverse. The two legs are never both high.
- R6: On a pair that has an enable pin, a deasserted pin enable parks the pair low/low, whether power-down is asserted or not and whatever `pd_mode` is.
- R7: A pair changes state only at a falling edge of `clk_ref`, so no shortened high pulse ever appears on either leg.
- R8: A pin change made after rising edge k shows at the outputs from the falling edge that follows rising edge k+2. Neither the output before that edge nor the output in the half cycle after rising edge k+1 changes. This is within three input clocks.
- R9: A change of `pair_en` or `pd_mode` made after a rising edge shows at the outputs from the very next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock that is buffered and that clocks the control logic |
| rst | input | 1 | Synchronous active-high reset |
| inv_pin | input | 1 | Polarity pin for the power-down and enable pins (asynchronous) |
| pd_pin | input | 1 | Power-down pin, active low when inv_pin=0 (asynchronous) |
| oe_pin | input | NUM_OUT | Per-pair enable pins; only bits set in OE_MASK are used (asynchronous) |
| pair_en | input | NUM_OUT | Per-pair register enable, 1 = enabled (clock domain) |
| pd_mode | input | 1 | Park choice under power-down: 0 = high/low, 1 = low/low |
| out_p | output | NUM_OUT | True leg of each pair |
| out_n | output | NUM_OUT | Complement leg of each pair |

## Verification
The assertions check on every cycle that the synchronized pins trail the raw pins by exactly two rising edges. They also check that power-down never yields a running pair, that a cleared register enable or a deasserted pin enable always gives a low/low command, and that a running pair shows true-high at each falling edge and complement-high at each rising edge, with the legs never both high. What they cannot show is that the whole decision table is correct across polarity, park mode and mixed pin and register settings, or the exact edge at which a change lands. The bench covers these: a vector table of control combinations checks both clock phases of each pair, and directed runs measure the latency of pins and of register bits and apply reset during operation.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

    // Drive state of one differential pair. Encoding is used by the bench table.
    typedef enum logic [1:0] {
        PAIR_LOW  = 2'd0,   // true low, complement low
        PAIR_HIGH = 2'd1,   // true high, complement low
        PAIR_RUN  = 2'd2    // follows the reference clock
    } pair_state_e;

    typedef struct packed {
        logic tru;
        logic cmp;
    } pair_level_t;

    // Pin sense after the polarity pin: power-down asserted
    function automatic logic pd_asserted(input logic inv, input logic pin);
        return inv ? pin : ~pin;
    endfunction

    // Pin sense after the polarity pin: enable pin asserted
    function automatic logic oe_asserted(input logic inv, input logic pin);
        return inv ? ~pin : pin;
    endfunction

    // Decision for one pair; pin enable is consulted only where a pin exists
    function automatic pair_state_e pair_decide(
        input logic has_pin,
        input logic oe_act,
        input logic reg_en,
        input logic pd_act,
        input logic park_low
    );
        pair_state_e r;
        if (!reg_en)                 r = PAIR_LOW;
        else if (has_pin && !oe_act) r = PAIR_LOW;
        else if (pd_act)             r = park_low ? PAIR_LOW : PAIR_HIGH;
        else                         r = PAIR_RUN;
        return r;
    endfunction

    // Static levels of a parked pair
    function automatic pair_level_t park_level(input pair_state_e s);
        pair_level_t l;
        l.tru = (s == PAIR_HIGH);
        l.cmp = 1'b0;
        return l;
    endfunction

endpackage

// File: rtl/clkgate_sync.sv
module clkgate_sync #(
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;
    logic [1:0]       warm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= din;
            stab_q <= meta_q;
        end
    end

    assign dout = stab_q;

    // Cycles since reset, saturating, so the lag check never looks before reset
    always_ff @(posedge clk) begin
        if (rst)                 warm_q <= 2'd0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    assert_sync_lag_R8: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd2) |-> (dout == $past(din, 2)));

endmodule

// File: rtl/clkgate_policy.sv
module clkgate_policy
    import clkgate_pkg::*;
#(
    parameter int                 NUM_OUT = 4,
    parameter logic [NUM_OUT-1:0] OE_MASK = 4'b1001
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            inv_s,
    input  logic                            pd_s,
    input  logic [NUM_OUT-1:0]              oe_s,
    input  logic [NUM_OUT-1:0]              reg_en,
    input  logic                            park_low,
    output pair_state_e [NUM_OUT-1:0]       cmd
);
    logic                pd_act;
    logic [NUM_OUT-1:0]  oe_act;

    assign pd_act = pd_asserted(inv_s, pd_s);

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_pair
        assign oe_act[i] = oe_asserted(inv_s, oe_s[i]);

        always_comb begin
            cmd[i] = pair_decide(OE_MASK[i], oe_act[i], reg_en[i], pd_act, park_low);
        end

        assert_pd_no_run_R4: assert property (@(posedge clk) disable iff (rst)
            pd_act |-> (cmd[i] != PAIR_RUN));

        assert_en_off_R3: assert property (@(posedge clk) disable iff (rst)
            !reg_en[i] |-> (cmd[i] == PAIR_LOW));

        if (OE_MASK[i]) begin : g_pin
            assert_oe_off_R6: assert property (@(posedge clk) disable iff (rst)
                !oe_act[i] |-> (cmd[i] == PAIR_LOW));
        end
    end

endmodule

// File: rtl/clkgate_pair.sv
module clkgate_pair
    import clkgate_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  pair_state_e cmd,
    output logic        out_p,
    output logic        out_n
);
    pair_state_e state_q;
    pair_level_t park;

    // State moves only on the falling edge: the clock is low from here on,
    // so a started high pulse has already completed and none is cut short.
    always_ff @(negedge clk) begin
        if (rst) state_q <= PAIR_LOW;
        else     state_q <= cmd;
    end

    assign park = park_level(state_q);

    always_comb begin
        if (state_q == PAIR_RUN) begin
            out_p = clk;
            out_n = ~clk;
        end else begin
            out_p = park.tru;
            out_n = park.cmp;
        end
    end

    assert_run_fall_R5: assert property (@(negedge clk) disable iff (rst)
        (state_q == PAIR_RUN) |-> (out_p && !out_n));

    assert_run_rise_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == PAIR_RUN) |-> (!out_p && out_n));

    assert_no_overlap_R7: assert property (@(negedge clk) disable iff (rst)
        !(out_p && out_n));

endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl
    import clkgate_pkg::*;
#(
    parameter int                 NUM_OUT = 4,
    parameter logic [NUM_OUT-1:0] OE_MASK = 4'b1001
) (
    input  logic               clk_ref,
    input  logic               rst,
    input  logic               inv_pin,
    input  logic               pd_pin,
    input  logic [NUM_OUT-1:0] oe_pin,
    input  logic [NUM_OUT-1:0] pair_en,
    input  logic               pd_mode,
    output logic [NUM_OUT-1:0] out_p,
    output logic [NUM_OUT-1:0] out_n
);
    localparam int SYNC_W = NUM_OUT + 2;

    logic [SYNC_W-1:0]          pins_raw;
    logic [SYNC_W-1:0]          pins_s;
    pair_state_e [NUM_OUT-1:0]  cmd;

    assign pins_raw = {inv_pin, pd_pin, oe_pin};

    clkgate_sync #(.WIDTH(SYNC_W)) u_sync (
        .clk  (clk_ref),
        .rst  (rst),
        .din  (pins_raw),
        .dout (pins_s)
    );

    clkgate_policy #(.NUM_OUT(NUM_OUT), .OE_MASK(OE_MASK)) u_policy (
        .clk      (clk_ref),
        .rst      (rst),
        .inv_s    (pins_s[SYNC_W-1]),
        .pd_s     (pins_s[SYNC_W-2]),
        .oe_s     (pins_s[NUM_OUT-1:0]),
        .reg_en   (pair_en),
        .park_low (pd_mode),
        .cmd      (cmd)
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        clkgate_pair u_pair (
            .clk   (clk_ref),
            .rst   (rst),
            .cmd   (cmd[i]),
            .out_p (out_p[i]),
            .out_n (out_n[i])
        );
    end

endmodule

// File: tb/clkgate_ctrl_tb_top.sv
`timescale 1ns/1ps
module clkgate_ctrl_tb_top;

    logic       clk_ref = 1'b0;
    logic       rst = 1'b1;
    logic       inv_pin = 1'b0;
    logic       pd_pin = 1'b1;
    logic [3:0] oe_pin = 4'b1111;
    logic [3:0] pair_en = 4'b1111;
    logic       pd_mode = 1'b0;
    logic [3:0] out_p;
    logic [3:0] out_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk_ref = ~clk_ref;   // 100 MHz

    clkgate_ctrl dut_i (
        .clk_ref (clk_ref),
        .rst     (rst),
        .inv_pin (inv_pin),
        .pd_pin  (pd_pin),
        .oe_pin  (oe_pin),
        .pair_en (pair_en),
        .pd_mode (pd_mode),
        .out_p   (out_p),
        .out_n   (out_n)
    );

    // Vector: [18] inv, [17] pd pin, [16:13] oe pins, [12:9] pair_en, [8] pd_mode,
    // [7:0] expected state per pair (2 bits each, pair 0 lowest): 0 low/low, 1 high/low, 2 run
    localparam int NV = 12;
    localparam logic [18:0] VEC [NV] = '{
        {1'b0, 1'b1, 4'b1111, 4'b1111, 1'b0, 8'b10_10_10_10}, // R5 running
        {1'b0, 1'b0, 4'b1111, 4'b1111, 1'b0, 8'b01_01_01_01}, // R4 park high
        {1'b0, 1'b0, 4'b1111, 4'b1111, 1'b1, 8'b00_00_00_00}, // R4 park low
        {1'b0, 1'b1, 4'b0110, 4'b1111, 1'b0, 8'b00_10_10_00}, // R6/R3 pins off, unused pins ignored
        {1'b0, 1'b1, 4'b1001, 4'b0110, 1'b0, 8'b00_10_10_00}, // R3 reg off on pin pairs
        {1'b0, 1'b1, 4'b1111, 4'b1001, 1'b0, 8'b10_00_00_10}, // R3 reg off on pinless pairs
        {1'b1, 1'b0, 4'b0000, 4'b1111, 1'b0, 8'b10_10_10_10}, // R2 inverted, running
        {1'b1, 1'b1, 4'b0000, 4'b1111, 1'b0, 8'b01_01_01_01}, // R2 inverted, powered down
        {1'b1, 1'b1, 4'b1111, 4'b1111, 1'b0, 8'b00_01_01_00}, // R6 pin off beats park high
        {1'b0, 1'b0, 4'b0000, 4'b1111, 1'b0, 8'b00_01_01_00}, // R6 pin off under power-down
        {1'b0, 1'b0, 4'b1111, 4'b0000, 1'b0, 8'b00_00_00_00}, // R3 all reg off
        {1'b1, 1'b0, 4'b1001, 4'b1111, 1'b1, 8'b00_10_10_00}  // R2 inverted pin off
    };

    task automatic check(input bit ok, input string req, input logic [1:0] act, input logic [1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual p/n=%b expected p/n=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Expected legs in the high (hi=1) or low phase for a state code
    function automatic logic [1:0] legs(input logic [1:0] code, input bit hi);
        case (code)
            2'd1:    return 2'b10;
            2'd2:    return hi ? 2'b10 : 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    task automatic check_pair(input int i, input logic [1:0] code, input string req);
        logic [1:0] hi_v, lo_v;
        @(posedge clk_ref); #2;
        hi_v = {out_p[i], out_n[i]};
        @(negedge clk_ref); #2;
        lo_v = {out_p[i], out_n[i]};
        check(hi_v == legs(code, 1'b1), req, hi_v, legs(code, 1'b1));
        check(lo_v == legs(code, 1'b0), req, lo_v, legs(code, 1'b0));
    endtask

    initial begin
        // R1: reset state in both phases
        repeat (3) @(posedge clk_ref);
        for (int i = 0; i < 4; i++) check_pair(i, 2'd0, "R1");
        @(posedge clk_ref); #2 rst = 1'b0;

        // Table walk (R2..R6)
        for (int v = 0; v < NV; v++) begin
            @(posedge clk_ref); #2;
            inv_pin = VEC[v][18]; pd_pin = VEC[v][17]; oe_pin = VEC[v][16:13];
            pair_en = VEC[v][12:9]; pd_mode = VEC[v][8];
            repeat (3) @(posedge clk_ref);
            for (int i = 0; i < 4; i++)
                check_pair(i, VEC[v][2*i +: 2], $sformatf("R2-table v%0d pair%0d", v, i));
        end

        // R8: pin latency, park high -> run after power-down release
        @(posedge clk_ref); #2;
        inv_pin = 1'b0; pd_pin = 1'b0; oe_pin = 4'b1111; pair_en = 4'b1111; pd_mode = 1'b0;
        repeat (4) @(posedge clk_ref);
        #2 pd_pin = 1'b1;                         // after rising edge k
        @(negedge clk_ref); #2;                   // low phase after k
        check(out_n[1] == 1'b0, "R8 before edge k+1", {out_p[1], out_n[1]}, 2'b10);
        @(negedge clk_ref); #2;                   // low phase after k+1
        check(out_n[1] == 1'b0, "R8 after edge k+1", {out_p[1], out_n[1]}, 2'b10);
        @(negedge clk_ref); #2;                   // low phase after k+2
        check({out_p[1], out_n[1]} == 2'b01, "R8 after edge k+2", {out_p[1], out_n[1]}, 2'b01);

        // R9 and R7: register enable acts at the next falling edge, high pulse intact
        @(posedge clk_ref); #2 pair_en[2] = 1'b0;
        check({out_p[2], out_n[2]} == 2'b10, "R7 pulse kept", {out_p[2], out_n[2]}, 2'b10);
        @(negedge clk_ref); #2;
        check({out_p[2], out_n[2]} == 2'b00, "R9 reg off next fall", {out_p[2], out_n[2]}, 2'b00);
        check({out_p[1], out_n[1]} == 2'b01, "R9 neighbour runs", {out_p[1], out_n[1]}, 2'b01);

        // R9: park mode change with power-down asserted
        @(posedge clk_ref); #2 pair_en = 4'b1111; pd_pin = 1'b0;
        repeat (4) @(posedge clk_ref);
        #2 pd_mode = 1'b1;
        check({out_p[0], out_n[0]} == 2'b10, "R9 before fall", {out_p[0], out_n[0]}, 2'b10);
        @(negedge clk_ref); #2;
        check({out_p[0], out_n[0]} == 2'b00, "R9 mode next fall", {out_p[0], out_n[0]}, 2'b00);

        // R1: reset during operation
        @(posedge clk_ref); #2 pd_pin = 1'b1; pd_mode = 1'b0;
        repeat (4) @(posedge clk_ref);
        #2 rst = 1'b1;
        @(negedge clk_ref); #2;
        check({out_p[3], out_n[3]} == 2'b00, "R1 reset mid-run", {out_p[3], out_n[3]}, 2'b00);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk_ref);
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual=hung expected=finished");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule